// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Line Codec

This block turns 10-bit parallel video words into the serial bit stream of a coaxial video link, and rebuilds the bit stream on the receive side. On transmit, a strobe that arrives once every ten bit clocks loads a word into a shift register. The bits leave most significant first, one per clock. Each bit passes through a self-synchronizing scrambler with taps four and nine bits back. It then passes through a toggle stage that gives a polarity-free NRZI line signal. Together these two stages form the generator (x^9 + x^4 + 1)(x + 1).

The receive half reverses the coding. It first takes the exclusive-or of each line bit with the previous one, which recovers the scrambled bit whatever the line polarity. It then cancels the scrambling using its own nine-bit history of recovered scrambled bits. The receiver needs no reset handshake, because its state is made only of received bits. Any wrong start state or any line corruption therefore flushes out by itself. Word alignment, clock recovery and the analog line stages lie outside this block.

Top module: `sdi_serial_codec`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tx_line` and `rx_bit` are 0.
- R2: An edge with `tx_load` high captures `tx_word`. The bit fed to the scrambler in the following ten cycles is `tx_word[9]`, then bit 8, and so on down to bit 0. If no further strobe arrives, zeros follow.
- R3: The scrambled bit is s[n] = d[n] xor s[n-4] xor s[n-9], where d[n] is the serialized bit. The scrambler history is zero after reset.
- R4: `tx_line` is a register that toggles at the edge after which scrambled bit s[n] = 1 has been consumed, and holds when s[n] = 0. `tx_line` therefore carries bit n one clock after the serializer presents it.
- R5: When `tx_line` is looped back to `rx_line`, `rx_bit` equals the data bit that the serializer presented two clocks earlier.
- R6: When the loop carries the inverted line signal, `rx_bit` again equals the transmitted data once the settling window has passed.
- R7: After any period of arbitrary bits on `rx_line`, `rx_bit` is correct from the eleventh correct received bit onward, without any reset.
- R8: Repeated stress words (0x300/0x198 and 0x200/0x110), which give long runs without transitions, are recovered with no bit lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_load | input | 1 | Word-load strobe, one cycle in every ten |
| tx_word | input | 10 | Parallel word to send |
| tx_line | output | 1 | NRZI-coded serial line bit |
| rx_line | input | 1 | Received serial line bit, either polarity |
| rx_bit | output | 1 | Recovered descrambled data bit |

## Verification
The assertions check four things on every cycle:
- the first serialized bit after a strobe is the word's top bit;
- the scrambled bit obeys the four- and nine-tap recurrence once nine cycles of history exist;
- the line toggles exactly when the previous scrambled bit was 1;
- the line is quiet just after reset.

The receive path's recovery needs scenarios in the bench instead. Recovery under inverted polarity, resynchronization after random line garbage, and loss-free transfer of stress patterns all depend on the two halves working together over many bits.

// File: rtl/sdi_codec_pkg.sv
package sdi_codec_pkg;
    localparam int WORD_W   = 10;
    localparam int TAP_NEAR = 4;
    localparam int TAP_FAR  = 9;
endpackage

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter #(
    parameter int W = sdi_codec_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);
    typedef struct packed {
        logic [W-1:0] shreg;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.shreg = word_i;
        end else begin
            state_d.shreg = {state_q.shreg[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bit_o = state_q.shreg[W-1];
endmodule

// File: rtl/sdi_tx_scrambler.sv
module sdi_tx_scrambler #(
    parameter int NEAR = sdi_codec_pkg::TAP_NEAR,
    parameter int FAR  = sdi_codec_pkg::TAP_FAR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    output logic scr_o,
    output logic line_o
);
    typedef struct packed {
        logic [FAR-1:0] hist;
        logic           line;
    } state_t;

    state_t state_d, state_q;
    logic   scr;

    always_comb begin
        scr          = data_i ^ state_q.hist[NEAR-1] ^ state_q.hist[FAR-1];
        state_d      = state_q;
        state_d.hist = {state_q.hist[FAR-2:0], scr};
        state_d.line = state_q.line ^ scr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign scr_o  = scr;
    assign line_o = state_q.line;
endmodule

// File: rtl/sdi_rx_descrambler.sv
module sdi_rx_descrambler #(
    parameter int NEAR = sdi_codec_pkg::TAP_NEAR,
    parameter int FAR  = sdi_codec_pkg::TAP_FAR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic data_o
);
    typedef struct packed {
        logic           prev;
        logic [FAR-1:0] hist;
        logic           dout;
    } state_t;

    state_t state_d, state_q;
    logic   scr_rx;

    always_comb begin
        scr_rx       = line_i ^ state_q.prev;
        state_d      = state_q;
        state_d.prev = line_i;
        state_d.hist = {state_q.hist[FAR-2:0], scr_rx};
        state_d.dout = scr_rx ^ state_q.hist[NEAR-1] ^ state_q.hist[FAR-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign data_o = state_q.dout;
endmodule

// File: rtl/sdi_serial_codec.sv
module sdi_serial_codec #(
    parameter int W    = sdi_codec_pkg::WORD_W,
    parameter int NEAR = sdi_codec_pkg::TAP_NEAR,
    parameter int FAR  = sdi_codec_pkg::TAP_FAR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_load,
    input  logic [W-1:0] tx_word,
    output logic         tx_line,
    input  logic         rx_line,
    output logic         rx_bit
);
    logic ser_bit;
    logic scr_bit;

    sdi_word_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tx_load),
        .word_i (tx_word),
        .bit_o  (ser_bit)
    );

    sdi_tx_scrambler #(.NEAR(NEAR), .FAR(FAR)) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (ser_bit),
        .scr_o  (scr_bit),
        .line_o (tx_line)
    );

    sdi_rx_descrambler #(.NEAR(NEAR), .FAR(FAR)) u_dscr (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .data_o (rx_bit)
    );
endmodule

// File: rtl/sdi_codec_chk.sv
module sdi_codec_chk #(
    parameter int W    = sdi_codec_pkg::WORD_W,
    parameter int NEAR = sdi_codec_pkg::TAP_NEAR,
    parameter int FAR  = sdi_codec_pkg::TAP_FAR
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_load,
    input logic [W-1:0] tx_word,
    input logic         ser_bit,
    input logic         scr_bit,
    input logic         tx_line
);
    logic [4:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 5'd31) warm_q <= warm_q + 5'd1;
    end

    // R1: line quiet in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 5'd0) |-> (tx_line == 1'b0));

    // R2: first serialized bit after a strobe is the word's top bit
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && warm_q >= 5'd1) |=> (ser_bit == $past(tx_word[W-1])));

    // R3: scrambler recurrence on taps NEAR and FAR
    p_scramble_taps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q > 5'(FAR)) |-> (scr_bit == (ser_bit ^ $past(scr_bit, NEAR) ^ $past(scr_bit, FAR))));

    // R4: line toggles exactly when the previous scrambled bit was 1
    p_nrzi_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 5'd2) |-> ((tx_line != $past(tx_line)) == $past(scr_bit)));
endmodule

bind sdi_serial_codec sdi_codec_chk #(.W(W), .NEAR(NEAR), .FAR(FAR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_load (tx_load),
    .tx_word (tx_word),
    .ser_bit (ser_bit),
    .scr_bit (scr_bit),
    .tx_line (tx_line)
);

// File: tb/sdi_serial_codec_tb.sv
`timescale 1ns/1ps
module sdi_serial_codec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load = 1'b0;
    logic [9:0] tx_word = '0;
    logic       tx_line;
    logic       rx_line;
    logic       rx_bit;

    logic       inv_en  = 1'b0;
    logic       junk_en = 1'b0;
    logic       junk_bit = 1'b0;

    assign rx_line = junk_en ? junk_bit : (inv_en ? ~tx_line : tx_line);

    always #2 clk = ~clk;

    sdi_serial_codec u_dut (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_word(tx_word),
        .tx_line(tx_line), .rx_line(rx_line), .rx_bit(rx_bit)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // bench reference state
    logic [9:0] m_word = '0;
    int         m_idx  = 10;
    logic [8:0] m_hist = '0;
    logic       m_y    = 1'b0;
    logic       prev_bit = 1'b0;
    logic       p1 = 1'b0, p2 = 1'b0;
    int         settle = 0;
    int         phase  = 0;
    string      rx_tag = "R5";

    function automatic logic scr_next(input logic d, input logic [8:0] h);
        return d ^ h[3] ^ h[8];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic step(input logic ld, input logic [9:0] w);
        logic s;
        logic cur;
        tx_load = ld;
        tx_word = w;
        @(posedge clk);
        s      = scr_next(prev_bit, m_hist);
        m_hist = {m_hist[7:0], s};
        m_y    = m_y ^ s;
        if (ld) begin m_word = w; m_idx = 0; end
        else if (m_idx < 10) m_idx++;
        cur = (m_idx < 10) ? m_word[9 - m_idx] : 1'b0;
        @(negedge clk);
        check("R2/R3/R4 tx_line", tx_line, m_y);
        if (settle > 0) settle--;
        else check(rx_tag, rx_bit, p2);
        p2 = p1;
        p1 = cur;
        prev_bit = cur;
    endtask

    task automatic send_word(input logic [9:0] w);
        step(1'b1, w);
        for (int k = 1; k < 10; k++) step(1'b0, '0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 tx_line in reset", tx_line, 1'b0);
        check("R1 rx_bit in reset", rx_bit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_line after release", tx_line, 1'b0);
        check("R1 rx_bit after release", rx_bit, 1'b0);
        // the release edge: model state stays at reset values
        p1 = 1'b0; p2 = 1'b0; prev_bit = 1'b0;

        // R2 directed: single one in the top bit, then all ones, then zeros
        rx_tag = "R5 directed";
        send_word(10'h200);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h001);
        for (int k = 0; k < 15; k++) step(1'b0, '0);   // R2: no strobe, zeros shift

        // R5 random loopback
        rx_tag = "R5 random";
        for (int k = 0; k < 200; k++) send_word(10'($urandom));

        // R6 inverted polarity
        inv_en = 1'b1; settle = 11; rx_tag = "R6 inverted";
        for (int k = 0; k < 150; k++) send_word(10'($urandom));
        inv_en = 1'b0; settle = 11; rx_tag = "R6 restored";
        for (int k = 0; k < 20; k++) send_word(10'($urandom));

        // R7 arbitrary line garbage then resync without reset
        for (int r = 0; r < 4; r++) begin
            junk_en = 1'b1; settle = 1000; rx_tag = "R7 resync";
            for (int k = 0; k < 37 + r * 5; k++) begin
                junk_bit = 1'($urandom);
                step((k % 10) == 0, 10'($urandom));
            end
            junk_en = 1'b0; settle = 11;
            inv_en = r[0];
            for (int k = 0; k < 30; k++) send_word(10'($urandom));
        end
        inv_en = 1'b0; settle = 11;

        // R8 stress patterns
        rx_tag = "R8 stress eq";
        for (int k = 0; k < 300; k++) send_word((k % 2) ? 10'h198 : 10'h300);
        rx_tag = "R8 stress pll";
        for (int k = 0; k < 300; k++) send_word((k % 2) ? 10'h110 : 10'h200);
        inv_en = 1'b1; settle = 11; rx_tag = "R8 stress inverted";
        for (int k = 0; k < 200; k++) send_word((k % 2) ? 10'h110 : 10'h200);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end
endmodule